// File: doc/BRIEF.md
# Multiprocessor Receiver Wakeup Controller

On a serial link shared by several processors, a node should only be told about the frame blocks meant for it. This block sits between the receiver's end-of-frame logic and the receive-data-full flag. It holds a receiver-wakeup bit (the "asleep" state). While that bit is set, every completed frame still produces a data-register load pulse. The data-full set pulse is withheld, so no receive interrupt follows.

The receiver clears its own wakeup bit when the selected wakeup pattern arrives. In idle-line mode the pattern is an idle character. In address-mark mode it is a frame whose mark bit (the most significant data bit) is 1. Software looks at the address frame that follows and decides whether to accept the block. If the block is not for this node, software sets the wakeup bit again and the remaining frames are skipped. Idle detection, bit sampling and address comparison are done elsewhere.

Top module: `mp_rx_wake`

## Requirements
- R1: After reset, `rxAsleep` is 0 and neither `loadPulse` nor `fullSetPulse` is high.
- R2: Every cycle with `frameDone` high is followed, one cycle later, by a one-cycle `loadPulse`, whether the receiver is asleep or awake. No `loadPulse` appears without a `frameDone` one cycle earlier.
- R3: A frame completed while `rxAsleep` is 0 produces a `fullSetPulse` one cycle after `frameDone`.
- R4: A frame completed while `rxAsleep` is 1 produces no `fullSetPulse`, unless it is the waking frame described in R6.
- R5: With `wakeMode` = 0 (idle-line), an `idleSeen` pulse while asleep clears `rxAsleep` on the next cycle.
- R6: With `wakeMode` = 1 (address-mark), a frame with `addrMark` = 1 completed while asleep clears `rxAsleep` on the next cycle. The same frame produces a `fullSetPulse`.
- R7: With `wakeMode` = 1, `idleSeen` has no effect on `rxAsleep`.
- R8: With `wakeMode` = 0, `addrMark` has no effect on `rxAsleep` or on `fullSetPulse`.
- R9: `swSetWake` sets `rxAsleep` on the next cycle. It takes precedence over a hardware wake event in the same cycle.
- R10: In idle-line mode, the first frame completed after an idle wake produces a `fullSetPulse`.
- R11: In the absence of `swSetWake` and of a wake event for the current mode, `rxAsleep` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameDone | input | 1 | One-cycle strobe: the last stop bit of a frame was received |
| addrMark | input | 1 | Mark bit (data MSB) of the frame flagged by `frameDone` |
| idleSeen | input | 1 | One-cycle pulse: an idle character was detected |
| wakeMode | input | 1 | Wakeup pattern select: 0 idle-line, 1 address-mark |
| swSetWake | input | 1 | Software write setting the wakeup bit |
| rxAsleep | output | 1 | Current receiver-wakeup bit |
| fullSetPulse | output | 1 | Gated set pulse for the receive-data-full flag |
| loadPulse | output | 1 | Data-register load pulse, never gated |

## Verification
The bench starts the receiver in each state and sweeps every combination of the five single-cycle inputs. It compares the next-cycle wakeup bit and both pulses against an arithmetic model.

This sweep reaches the corner cases that matter:
- **Software set against a same-cycle wake.** A design with the priority reversed would leave the receiver awake.
- **Cross-mode inputs.** A design that ignored `wakeMode` would wake on an idle pulse in address-mark mode, or on a mark bit in idle-line mode.
- **Gating of the loads.** A design that gated the load pulse along with the flag would drop data while asleep.
- **The waking address-mark frame.** A design that flagged only frames arriving after wakeup would lose that frame's data-full notification.

A directed sequence checks that the frame after an idle wake is flagged.

// File: rtl/mpw_pkg.sv
package mpw_pkg;

  // Wakeup pattern selector
  typedef enum logic {
    WAKE_IDLE = 1'b0,
    WAKE_MARK = 1'b1
  } wakeMode_e;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic frameIn;   // a frame completed this cycle
    logic gateOpen;  // that frame may raise the data-full flag
  } dpStrobes_t;

endpackage

// File: rtl/mpw_ctl.sv
module mpw_ctl
  import mpw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frameDone,
  input  logic       addrMark,
  input  logic       idleSeen,
  input  wakeMode_e  wakeMode,
  input  logic       swSetWake,
  output logic       asleep,
  output dpStrobes_t strobes
);

  logic idleWake;
  logic markWake;
  logic anyWake;

  always_comb begin
    idleWake = asleep && (wakeMode == WAKE_IDLE) && idleSeen;
    markWake = asleep && (wakeMode == WAKE_MARK) && frameDone && addrMark;
    anyWake  = idleWake || markWake;
    strobes.frameIn  = frameDone;
    // an awake receiver flags every frame; the waking mark frame is flagged too
    strobes.gateOpen = !asleep || markWake;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asleep <= 1'b0;
    end else if (swSetWake) begin
      asleep <= 1'b1;   // software wins over a same-cycle wake
    end else if (anyWake) begin
      asleep <= 1'b0;
    end
  end

endmodule

// File: rtl/mpw_dp.sv
module mpw_dp
  import mpw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dpStrobes_t strobes,
  output logic       loadPulse,
  output logic       fullSetPulse
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loadPulse    <= 1'b0;
      fullSetPulse <= 1'b0;
    end else begin
      loadPulse    <= strobes.frameIn;
      fullSetPulse <= strobes.frameIn && strobes.gateOpen;
    end
  end

endmodule

// File: rtl/mp_rx_wake.sv
module mp_rx_wake
  import mpw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frameDone,
  input  logic addrMark,
  input  logic idleSeen,
  input  logic wakeMode,
  input  logic swSetWake,
  output logic rxAsleep,
  output logic fullSetPulse,
  output logic loadPulse
);

  dpStrobes_t strobes;
  wakeMode_e  modeSel;

  assign modeSel = wakeMode_e'(wakeMode);

  mpw_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .frameDone (frameDone),
    .addrMark  (addrMark),
    .idleSeen  (idleSeen),
    .wakeMode  (modeSel),
    .swSetWake (swSetWake),
    .asleep    (rxAsleep),
    .strobes   (strobes)
  );

  mpw_dp u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .loadPulse    (loadPulse),
    .fullSetPulse (fullSetPulse)
  );

endmodule

// File: rtl/mpw_chk.sv
module mpw_chk (
  input logic clk,
  input logic rst_n,
  input logic frameDone,
  input logic addrMark,
  input logic idleSeen,
  input logic wakeMode,
  input logic swSetWake,
  input logic rxAsleep,
  input logic fullSetPulse,
  input logic loadPulse
);

  // R2
  load_follows_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |=> loadPulse);

  // R2
  no_stray_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frameDone |=> !loadPulse);

  // R3
  awake_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxAsleep && frameDone) |=> fullSetPulse);

  // R4
  asleep_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxAsleep && frameDone && !(wakeMode && addrMark)) |=> !fullSetPulse);

  // R5
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxAsleep && !wakeMode && idleSeen && !swSetWake) |=> !rxAsleep);

  // R6
  mark_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxAsleep && wakeMode && frameDone && addrMark && !swSetWake) |=> (!rxAsleep && fullSetPulse));

  // R9
  sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swSetWake |=> rxAsleep);

  // R7
  mark_mode_idle_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxAsleep && wakeMode && !frameDone && !swSetWake) |=> rxAsleep);

endmodule

bind mp_rx_wake mpw_chk u_mpw_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frameDone    (frameDone),
  .addrMark     (addrMark),
  .idleSeen     (idleSeen),
  .wakeMode     (wakeMode),
  .swSetWake    (swSetWake),
  .rxAsleep     (rxAsleep),
  .fullSetPulse (fullSetPulse),
  .loadPulse    (loadPulse)
);

// File: tb/tb_mp_rx_wake.sv
module tb_mp_rx_wake;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frameDone = 1'b0;
  logic addrMark = 1'b0;
  logic idleSeen = 1'b0;
  logic wakeMode = 1'b0;
  logic swSetWake = 1'b0;
  logic rxAsleep;
  logic fullSetPulse;
  logic loadPulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mp_rx_wake dut (
    .clk(clk), .rst_n(rst_n), .frameDone(frameDone), .addrMark(addrMark),
    .idleSeen(idleSeen), .wakeMode(wakeMode), .swSetWake(swSetWake),
    .rxAsleep(rxAsleep), .fullSetPulse(fullSetPulse), .loadPulse(loadPulse)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    {frameDone, addrMark, idleSeen, swSetWake} = '0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic goToSleep();
    @(negedge clk);
    swSetWake = 1'b1;
    @(posedge clk); #1;
    check("R9", "rxAsleep after software set", rxAsleep, 1'b1);
    @(negedge clk);
    swSetWake = 1'b0;
  endtask

  // one cycle of stimulus, outputs sampled just after the capturing edge
  task automatic applyCycle(input logic fd, input logic mk, input logic id,
                            input logic md, input logic sw);
    @(negedge clk);
    frameDone = fd; addrMark = mk; idleSeen = id; wakeMode = md; swSetWake = sw;
    @(posedge clk); #1;
    @(negedge clk);
    {frameDone, addrMark, idleSeen, swSetWake} = '0;
  endtask

  initial begin
    doReset();
    #1;
    // R1
    check("R1", "rxAsleep after reset", rxAsleep, 1'b0);
    check("R1", "loadPulse after reset", loadPulse, 1'b0);
    check("R1", "fullSetPulse after reset", fullSetPulse, 1'b0);

    // exhaustive sweep: starting state x five single-cycle inputs
    for (int st = 0; st < 2; st++) begin
      for (int v = 0; v < 32; v++) begin
        logic fd, mk, id, md, sw, s;
        logic expSleep, expFull, wake;
        string sreq, freq;
        {fd, mk, id, md, sw} = v[4:0];
        s = st[0];
        doReset();
        if (s) goToSleep();
        @(negedge clk);
        wakeMode = md;
        wake = s && ((!md && id) || (md && fd && mk));
        expSleep = sw ? 1'b1 : (wake ? 1'b0 : s);
        expFull = fd && (!s || (md && mk));
        if (sw) sreq = "R9";
        else if (wake) sreq = md ? "R6" : "R5";
        else if (s && md && id) sreq = "R7";
        else if (s && !md && mk) sreq = "R8";
        else sreq = "R11";
        if (!fd) freq = "R2";
        else if (!s) freq = "R3";
        else if (md && mk) freq = "R6";
        else if (!md && mk) freq = "R8";
        else freq = "R4";
        frameDone = fd; addrMark = mk; idleSeen = id; swSetWake = sw;
        @(posedge clk); #1;
        check(sreq, $sformatf("rxAsleep st=%0d in=%05b", st, v[4:0]), rxAsleep, expSleep);
        check(freq, $sformatf("fullSetPulse st=%0d in=%05b", st, v[4:0]), fullSetPulse, expFull);
        check("R2", $sformatf("loadPulse st=%0d in=%05b", st, v[4:0]), loadPulse, fd);
        @(negedge clk);
        {frameDone, addrMark, idleSeen, swSetWake} = '0;
        @(posedge clk); #1;
        check("R2", "loadPulse lasts one cycle", loadPulse, 1'b0);
      end
    end

    // R10: idle wake, then an unmarked frame is flagged
    doReset();
    goToSleep();
    applyCycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R4", "sleeping frame not flagged", fullSetPulse, 1'b0);
    applyCycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R5", "idle wakes receiver", rxAsleep, 1'b0);
    applyCycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10", "address frame after idle wake flagged", fullSetPulse, 1'b1);
    applyCycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9", "software returns receiver to sleep", rxAsleep, 1'b1);
    applyCycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R4", "rest of block skipped", fullSetPulse, 1'b0);
    check("R2", "skipped frame still loads", loadPulse, 1'b1);
    repeat (3) applyCycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R11", "sleep holds over quiet cycles", rxAsleep, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule